// File: doc/BRIEF.md
# Saw/Triangle PWM Timer with Buffered Compare

A single-channel PWM timer. A counter runs against a programmable period value. It can produce a sawtooth that counts up or down, or a symmetric triangle. Two compare channels, A and B, each drive one PWM output. Software reaches the block through a simple write port. It writes a control word, the period, and the two compare buffers.

Each compare channel keeps a software-visible buffer and an active compare value. With buffering enabled, the buffer is copied into the active value only at a waveform boundary. That boundary is the wrap of the sawtooth, or the peak and the bottom of the triangle, so a duty change never takes effect part-way through a pulse. With buffering disabled, a write lands in the active value at once. A lock input freezes the period against writes.

Top module: `wpt_timer`

## Requirements
- R1: After reset the counter, both active compare values and both PWM outputs are 0, the period reads all ones, and the control word is 0: sawtooth, up-count, both buffers off, and counting stopped.
- R2: Write port addresses are: 0 control, 1 period, 2 compare A, 3 compare B. Control bits are: bit0 triangle mode, bit1 down-count (sawtooth only), bit2 buffer enable A, bit3 buffer enable B, bit4 run. In sawtooth up-count mode the counter steps 0,1,...,P and then wraps to 0, so one cycle lasts P+1 clocks.
- R3: In sawtooth down-count mode the counter steps P,...,1,0 and then reloads P, so one cycle lasts P+1 clocks.
- R4: In triangle mode the counter rises 0 to P and falls back toward 0. It does not repeat either end value, so one cycle lasts 2·P clocks.
- R5: While `prd_lock` is high, a period write has no effect on the period.
- R6: In sawtooth up-count mode with buffering on, the active compare value takes the buffer only on the clock edge at which the counter wraps from P to 0.
- R7: In sawtooth down-count mode with buffering on, the transfer happens only on the clock edge at which the counter reloads from 0 to P.
- R8: In triangle mode with buffering on, the transfer happens at the peak (counter at P while rising) and again at the bottom (counter at 0).
- R9: With buffering off for a channel, a compare write appears as the active value on the next clock.
- R10: In sawtooth mode an output goes high at cycle start, which is counter 0 when counting up and P when counting down. It goes low on the clock after the counter equals the active value. The output is therefore high for C clocks per cycle when counting up and for P−C clocks when counting down.
- R11: In triangle mode an output goes high at the bottom, goes low on a compare match while rising, and goes high again on a match while falling. It is high for 2·C clocks of each 2·P cycle.
- R12: A buffer write that falls on the same edge as a transfer sends the old buffer value to the active value. The new value is kept for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 period, 2 compare A, 3 compare B) |
| wr_data | input | 16 | Write data |
| prd_lock | input | 1 | Blocks period writes while high |
| pwm_a | output | 1 | PWM output of channel A |
| pwm_b | output | 1 | PWM output of channel B |
| cnt_out | output | 16 | Current counter value |
| prd_out | output | 16 | Current period value |
| cmp_a_out | output | 16 | Active compare value of channel A |
| cmp_b_out | output | 16 | Active compare value of channel B |

## Verification
A software write to a compare buffer can land on the very edge where the counter wraps and a buffer transfer fires. The bench provokes this by waiting until the counter is sampled at P and then driving the buffer write for that edge. It first loads the buffer with a different value, so that an old-value transfer and a new-value transfer can be told apart. The result is judged on the active compare value one clock later, which must hold the earlier buffer contents, and again after the following wrap, which must hold the newly written value.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

   typedef enum logic {WAVE_SAW = 1'b0, WAVE_TRI = 1'b1} wave_e;

   // field order fixes the bit positions software uses (bit0 = wave)
   typedef struct packed {
      logic  run;
      logic  buf_b;
      logic  buf_a;
      logic  down;
      wave_e wave;
   } wpt_ctrl_t;

   localparam int CTRL_W = $bits(wpt_ctrl_t);

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_PRD  = 2'd1;
   localparam logic [1:0] ADR_CMPA = 2'd2;

endpackage

// File: rtl/wpt_counter.sv
module wpt_counter
   import wpt_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  wave_e         wave,
   input  logic          down,
   input  logic [CW-1:0] prd,
   output logic [CW-1:0] cnt,
   output logic          going_up,
   output logic          start,
   output logic          xfer
);

   logic tri_up;
   logic saw_wrap, saw_reload, tri_peak, tri_floor;

   assign saw_wrap   = run && (wave == WAVE_SAW) && !down && (cnt >= prd);
   assign saw_reload = run && (wave == WAVE_SAW) &&  down && (cnt == '0);
   assign tri_peak   = run && (wave == WAVE_TRI) && tri_up && (cnt >= prd);
   assign tri_floor  = run && (wave == WAVE_TRI) && (cnt == '0);
   assign xfer       = saw_wrap | saw_reload | tri_peak | tri_floor;

   assign going_up = (wave == WAVE_TRI) ? tri_up : !down;
   assign start    = run && ((wave == WAVE_SAW && down) ? (cnt == prd) : (cnt == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         tri_up <= 1'b1;
      end else if (run) begin
         if (wave == WAVE_SAW) begin
            tri_up <= 1'b1;
            if (!down) cnt <= (cnt >= prd) ? '0 : cnt + 1'b1;
            else       cnt <= (cnt == '0) ? prd : cnt - 1'b1;
         end else if (prd == '0) begin
            cnt    <= '0;
            tri_up <= 1'b1;
         end else if (tri_up) begin
            if (cnt >= prd) begin
               cnt    <= prd - 1'b1;
               tri_up <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            if (cnt == '0) begin
               cnt    <= {{(CW-1){1'b0}}, 1'b1};
               tri_up <= 1'b1;
            end else if (cnt == {{(CW-1){1'b0}}, 1'b1}) begin
               cnt    <= '0;
               tri_up <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R2
   saw_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wave == WAVE_SAW && !down && cnt == prd) |=> (cnt == '0));

   // R3
   saw_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wave == WAVE_SAW && down && cnt == '0) |=> (cnt == $past(prd)));

   // R4
   tri_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wave == WAVE_TRI && tri_up && cnt == prd && prd > 1) |=>
         (cnt == $past(prd) - 1'b1 && !going_up));

endmodule

// File: rtl/wpt_cmp.sv
module wpt_cmp
   import wpt_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  wave_e         wave,
   input  logic          going_up,
   input  logic          start,
   input  logic          xfer,
   input  logic [CW-1:0] cnt,
   input  logic          buf_en,
   input  logic          wr,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] act,
   output logic          out
);

   logic [CW-1:0] shadow;
   logic          match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         act    <= '0;
      end else if (buf_en) begin
         if (xfer) act    <= shadow;
         if (wr)   shadow <= wr_data;
      end else if (wr) begin
         shadow <= wr_data;
         act    <= wr_data;
      end
   end

   assign match = run && (cnt == act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        out <= 1'b0;
      else if (match && wave == WAVE_TRI) out <= !going_up;
      else if (match)                     out <= 1'b0;
      else if (start)                     out <= 1'b1;
   end

   // R6 R7 R8 (active value moves only at a boundary or a direct write)
   cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer && !wr) |=> $stable(act));

   // R12
   cmp_old_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && buf_en) |=> (act == $past(shadow)));

   // R10
   saw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && wave == WAVE_SAW) |=> !out);

endmodule

// File: rtl/wpt_timer.sv
module wpt_timer
   import wpt_pkg::*;
#(
   parameter int            CW      = 16,
   parameter logic [CW-1:0] PRD_RST = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic          prd_lock,
   output logic          pwm_a,
   output logic          pwm_b,
   output logic [CW-1:0] cnt_out,
   output logic [CW-1:0] prd_out,
   output logic [CW-1:0] cmp_a_out,
   output logic [CW-1:0] cmp_b_out
);

   localparam int NCH = 2;

   if (CW < CTRL_W || CW > 32) begin : g_bad_width
      $error("wpt_timer: CW must lie between the control width and 32");
   end

   wpt_ctrl_t     ctrl;
   logic [CW-1:0] prd;
   logic [CW-1:0] cnt;
   logic          going_up, start, xfer;
   logic [CW-1:0] act_w [NCH];
   logic          out_w [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         prd  <= PRD_RST;
      end else if (wr_en) begin
         if (wr_addr == ADR_CTRL)             ctrl <= wpt_ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_addr == ADR_PRD && !prd_lock) prd  <= wr_data;
      end
   end

   wpt_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .wave(ctrl.wave),
      .down(ctrl.down), .prd(prd), .cnt(cnt), .going_up(going_up),
      .start(start), .xfer(xfer)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel, ben;
      assign sel = wr_en && (wr_addr == ADR_CMPA + 2'(i));
      assign ben = (i == 0) ? ctrl.buf_a : ctrl.buf_b;
      wpt_cmp #(.CW(CW)) u_cmp (
         .clk(clk), .rst_n(rst_n), .run(ctrl.run), .wave(ctrl.wave),
         .going_up(going_up), .start(start), .xfer(xfer), .cnt(cnt),
         .buf_en(ben), .wr(sel), .wr_data(wr_data),
         .act(act_w[i]), .out(out_w[i])
      );
   end

   assign pwm_a     = out_w[0];
   assign pwm_b     = out_w[1];
   assign cmp_a_out = act_w[0];
   assign cmp_b_out = act_w[1];
   assign cnt_out   = cnt;
   assign prd_out   = prd;

   // R5
   prd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prd_lock |=> $stable(prd));

endmodule

// File: tb/wpt_timer_tb.sv
module wpt_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        prd_lock = 1'b0;
   logic        pwm_a, pwm_b;
   logic [15:0] cnt_out, prd_out, cmp_a_out, cmp_b_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   wpt_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .prd_lock(prd_lock), .pwm_a(pwm_a), .pwm_b(pwm_b),
      .cnt_out(cnt_out), .prd_out(prd_out), .cmp_a_out(cmp_a_out),
      .cmp_b_out(cmp_b_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive a write at the current negedge; returns at the next negedge
   task automatic wr_now(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_cnt(input int v);
      for (int k = 0; k < 300; k++) begin
         if (cnt_out == 16'(v)) return;
         @(negedge clk);
      end
      chk("wait for counter value", int'(cnt_out), v);
   endtask

   task automatic measure(input bit chb, output int per, output int hi);
      logic prev, cur;
      per = 0; hi = 0;
      cur = chb ? pwm_b : pwm_a;
      for (int k = 0; k < 300; k++) begin
         prev = cur;
         @(negedge clk);
         cur = chb ? pwm_b : pwm_a;
         if (!prev && cur) break;
      end
      for (int k = 0; k < 300; k++) begin
         hi += int'(cur);
         per++;
         prev = cur;
         @(negedge clk);
         cur = chb ? pwm_b : pwm_a;
         if (!prev && cur) break;
      end
   endtask

   task automatic t_reset;
      chk("R1 counter", int'(cnt_out), 0);
      chk("R1 pwm_a", int'(pwm_a), 0);
      chk("R1 pwm_b", int'(pwm_b), 0);
      chk("R1 compare A", int'(cmp_a_out), 0);
      chk("R1 period", int'(prd_out), 16'hFFFF);
      repeat (3) @(negedge clk);
      chk("R1 stopped counter", int'(cnt_out), 0);
   endtask

   task automatic t_setup_direct;
      wr_now(2'd1, 16'd9);
      wr_now(2'd2, 16'd4);
      chk("R9 direct write A", int'(cmp_a_out), 4);
      wr_now(2'd3, 16'd7);
      chk("R9 direct write B", int'(cmp_b_out), 7);
   endtask

   task automatic t_saw_up;
      int per, hi, mx;
      wr_now(2'd0, 16'h001C);
      mx = 0;
      for (int k = 0; k < 30; k++) begin
         if (int'(cnt_out) > mx) mx = int'(cnt_out);
         @(negedge clk);
      end
      chk("R2 counter peak", mx, 9);
      measure(1'b0, per, hi);
      chk("R2 saw up period", per, 10);
      chk("R10 saw up high A", hi, 4);
      measure(1'b1, per, hi);
      chk("R10 saw up high B", hi, 7);
   endtask

   task automatic t_saw_up_xfer;
      wait_cnt(3);
      wr_now(2'd2, 16'd2);
      while (cnt_out != 16'd9) begin
         chk("R6 hold before wrap", int'(cmp_a_out), 4);
         @(negedge clk);
      end
      chk("R6 hold at P", int'(cmp_a_out), 4);
      @(negedge clk);
      chk("R6 moved after wrap", int'(cmp_a_out), 2);
      chk("R2 wrapped to zero", int'(cnt_out), 0);
   endtask

   task automatic t_collide;
      wait_cnt(5);
      wr_now(2'd2, 16'd3);
      wait_cnt(9);
      wr_now(2'd2, 16'd6);
      chk("R12 old buffer taken", int'(cmp_a_out), 3);
      wait_cnt(9);
      @(negedge clk);
      chk("R12 new buffer next wrap", int'(cmp_a_out), 6);
   endtask

   task automatic t_saw_down;
      int per, hi;
      wr_now(2'd0, 16'h001E);
      measure(1'b0, per, hi);
      chk("R3 saw down period", per, 10);
      chk("R10 saw down high A", hi, 3);
      wait_cnt(6);
      wr_now(2'd2, 16'd5);
      while (cnt_out != 16'd0) begin
         chk("R7 hold before reload", int'(cmp_a_out), 6);
         @(negedge clk);
      end
      @(negedge clk);
      chk("R7 moved after reload", int'(cmp_a_out), 5);
      chk("R3 reloaded to P", int'(cnt_out), 9);
   endtask

   task automatic t_lock;
      int per, hi;
      prd_lock = 1'b1;
      wr_now(2'd1, 16'd20);
      chk("R5 locked period", int'(prd_out), 9);
      measure(1'b0, per, hi);
      chk("R5 locked cycle length", per, 10);
      prd_lock = 1'b0;
      wr_now(2'd1, 16'd8);
      chk("R5 unlocked period", int'(prd_out), 8);
   endtask

   task automatic t_triangle;
      int per, hi, mx, npk;
      wr_now(2'd0, 16'h001D);
      wr_now(2'd2, 16'd3);
      repeat (40) @(negedge clk);
      chk("R8 transfer reached", int'(cmp_a_out), 3);
      mx = 0; npk = 0;
      for (int k = 0; k < 32; k++) begin
         if (int'(cnt_out) > mx) mx = int'(cnt_out);
         if (cnt_out == 16'd8) npk++;
         @(negedge clk);
      end
      chk("R4 triangle peak", mx, 8);
      chk("R4 peak not repeated", npk, 2);
      measure(1'b0, per, hi);
      chk("R4 triangle period", per, 16);
      chk("R11 triangle high A", hi, 6);
   endtask

   task automatic t_tri_xfer;
      logic [15:0] prev;
      prev = cnt_out;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (cnt_out == 16'd2 && prev == 16'd1) break;
         prev = cnt_out;
      end
      wr_now(2'd2, 16'd2);
      while (cnt_out != 16'd8) begin
         chk("R8 hold while rising", int'(cmp_a_out), 3);
         @(negedge clk);
      end
      @(negedge clk);
      chk("R8 moved at peak", int'(cmp_a_out), 2);
      wr_now(2'd2, 16'd1);
      while (cnt_out != 16'd0) begin
         chk("R8 hold while falling", int'(cmp_a_out), 2);
         @(negedge clk);
      end
      @(negedge clk);
      chk("R8 moved at bottom", int'(cmp_a_out), 1);
   endtask

   task automatic t_unbuffered;
      wr_now(2'd0, 16'h0019);
      wr_now(2'd2, 16'd7);
      chk("R9 unbuffered write A", int'(cmp_a_out), 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setup_direct();
      t_saw_up();
      t_saw_up_xfer();
      t_collide();
      t_saw_down();
      t_lock();
      t_triangle();
      t_tri_xfer();
      t_unbuffered();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (R1..): actual expired expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule